// File: doc/BRIEF.md
# CPU Exception Priority Controller

This block sits next to a CPU sequencer and decides when exception handling begins and which of four sources wins: reset, trace, interrupt or trap. A reset request comes from a rising edge on an external reset pin, which is synchronised first, or from a single-cycle watchdog overflow strobe. A reset is offered at once. Trace and interrupt are weighed only when the sequencer signals a boundary. A boundary is either the retirement of an instruction, which comes with a class code, or the end of an exception-handling sequence. Some instruction classes suppress trace or interrupt at their own boundary. A trap strobe is latched and is never masked.

The decision is offered to the sequencer as a held request, and `ack_i` acts as the ready signal. `take_o` is non-zero while an offer is valid. The offer, its type and its vector index stay stable until the cycle in which `ack_i` is high. The one exception is a reset event, which may replace any offer that has not been acknowledged. Leaving `ack_i` low is the only back-pressure the sequencer has. Boundaries reported while an offer is outstanding are ignored. The sequencer fetches its start address from the vector table entry that `vec_idx_o` names.

Top module: `exc_prio_ctrl`

## Requirements
- R1: A reset event is either a watchdog strobe or a 0-to-1 change on `reset_pin_i`. A watchdog strobe is offered at the next rising edge. A pin rise is offered SYNC_STAGES+1 rising edges after it is sampled. Either one is offered whatever the boundary inputs or any outstanding offer.
- R2: `take_o` is zero or one-hot: bit 0 = reset, bit 1 = trace, bit 2 = interrupt, bit 3 = trap. `exc_type_o` encodes none=0, reset=1, trace=2, interrupt=3, trap=4. While an offer is outstanding and `ack_i` is low, the offer stays unchanged unless a reset event replaces it. `ack_i` clears the offer at the next edge. With no offer outstanding, `ack_i` has no effect.
- R3: Trace, interrupt and trap are offered only at the edge after a cycle in which `insn_done_i` or `seq_done_i` is high and no offer is outstanding. A boundary reported while an offer is outstanding, including the cycle of its `ack_i`, is ignored.
- R4: When several sources qualify at one boundary, the order is trace, then interrupt, then trap.
- R5: Trace qualifies only when `trace_en_i` is 1 and `icm_i` equals 2. It never qualifies at an instruction boundary whose class code is 1 (return from exception).
- R6: An interrupt does not qualify at an instruction boundary whose class code is 2, 3, 4 or 5. These are the condition-register AND, OR, XOR and load classes.
- R7: Acknowledging a reset offer blocks interrupts at every boundary until an instruction boundary (`insn_done_i`) occurs. That instruction boundary itself may take an interrupt.
- R8: A trap strobe is never masked. It is taken at the first usable boundary at which no trace or interrupt qualifies, either at that same cycle or later. While a trap is pending, further trap strobes are ignored.
- R9: A reset event discards any pending trap. A trap strobe in the same cycle as a reset event, or while a reset offer is outstanding, is dropped.
- R10: The vector index is 0 for reset and 5 for trace. For a trap it is 8 plus the 2-bit trap operand captured with the strobe. For an interrupt it is `irq_vec_i` as sampled at the boundary.
- R11: After `rst_n` is released, there is no offer, no trap is pending and interrupts are not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_pin_i | input | 1 | External reset pin, asynchronous, rising edge requests reset |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| trace_en_i | input | 1 | Trace enable bit |
| icm_i | input | 2 | Interrupt control mode |
| irq_req_i | input | 1 | Pending interrupt request |
| irq_vec_i | input | VEC_W | Vector index supplied by the interrupt source |
| trap_i | input | 1 | Trap instruction strobe |
| trap_op_i | input | 2 | Trap operand |
| insn_done_i | input | 1 | Instruction retired this cycle |
| class_i | input | 3 | Class code of the retiring instruction |
| seq_done_i | input | 1 | Exception-handling sequence finished this cycle |
| ack_i | input | 1 | Sequencer accepts the outstanding offer |
| take_o | output | 4 | One-hot exception offer |
| exc_type_o | output | 3 | Encoded exception type |
| vec_idx_o | output | VEC_W | Vector table index |

## Verification
The hardest case to reach is a trap that is taken late. The trap must lose at its own boundary to a higher source, survive the acknowledge of that source, and then either win at a later boundary or be wiped out by a reset. The stimulus gets there in two scenes. In the first, a trap strobe goes out together with a qualifying trace and interrupt; trace is acknowledged, then interrupt, and then a plain boundary follows. In the second, the trap strobe is sent while no boundary is present, and the pin rise then follows. A behavioural model tracks pending traps and the synchronised pin history in queues and checks the outputs on every cycle.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

  localparam int NUM_SRC   = 4;
  localparam int SRC_RST   = 0;
  localparam int SRC_TRACE = 1;
  localparam int SRC_IRQ   = 2;
  localparam int SRC_TRAP  = 3;

  localparam int CLS_W = 3;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_RESET = 3'd1,
    EXC_TRACE = 3'd2,
    EXC_IRQ   = 3'd3,
    EXC_TRAP  = 3'd4
  } exc_type_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN    = 3'd0,
    CLS_EXC_RET  = 3'd1,
    CLS_CCR_AND  = 3'd2,
    CLS_CCR_OR   = 3'd3,
    CLS_CCR_XOR  = 3'd4,
    CLS_CCR_LOAD = 3'd5
  } insn_cls_e;

  function automatic logic is_ccr_class(input logic [CLS_W-1:0] c);
    return (c == CLS_CCR_AND) || (c == CLS_CCR_OR) ||
           (c == CLS_CCR_XOR) || (c == CLS_CCR_LOAD);
  endfunction

endpackage

// File: rtl/exc_rst_detect.sv
module exc_rst_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic wdt_i,
  output logic rst_ev_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rst_ev_o = (sync_q[STAGES-1] & ~prev_q) | wdt_i;

endmodule

// File: rtl/exc_boundary_qual.sv
module exc_boundary_qual
  import exc_prio_pkg::*;
#(
  parameter int          ICM_W      = 2,
  parameter logic [1:0]  TRACE_MODE = 2'd2
) (
  input  logic             insn_done_i,
  input  logic [CLS_W-1:0] class_i,
  input  logic             trace_en_i,
  input  logic [ICM_W-1:0] icm_i,
  input  logic             irq_req_i,
  input  logic             post_rst_i,
  output logic             trace_ok_o,
  output logic             irq_ok_o
);

  logic trace_mode_on;
  logic trace_inhibit;
  logic irq_inhibit;

  always_comb begin
    trace_mode_on = trace_en_i && (icm_i == ICM_W'(TRACE_MODE));
    trace_inhibit = insn_done_i && (class_i == CLS_EXC_RET);
    if (insn_done_i) irq_inhibit = is_ccr_class(class_i);
    else             irq_inhibit = post_rst_i;
    trace_ok_o = trace_mode_on && !trace_inhibit;
    irq_ok_o   = irq_req_i && !irq_inhibit;
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/exc_prio_ctrl.sv
module exc_prio_ctrl
  import exc_prio_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TRACE_VEC   = 5,
  parameter int TRAP_BASE   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reset_pin_i,
  input  logic                    wdt_ovf_i,
  input  logic                    trace_en_i,
  input  logic [1:0]              icm_i,
  input  logic                    irq_req_i,
  input  logic [VEC_W-1:0]        irq_vec_i,
  input  logic                    trap_i,
  input  logic [1:0]              trap_op_i,
  input  logic                    insn_done_i,
  input  logic [2:0]              class_i,
  input  logic                    seq_done_i,
  input  logic                    ack_i,
  output logic [NUM_SRC-1:0]      take_o,
  output logic [2:0]              exc_type_o,
  output logic [VEC_W-1:0]        vec_idx_o
);

  localparam int ARB_N = NUM_SRC - 1;  // trace, irq, trap
  localparam int A_TRACE = SRC_TRACE - 1;
  localparam int A_IRQ   = SRC_IRQ - 1;
  localparam int A_TRAP  = SRC_TRAP - 1;

  logic             rst_ev;
  logic             trace_ok, irq_ok;
  logic [ARB_N-1:0] arb_req, arb_gnt;

  logic             off_vld_q;
  exc_type_e        off_type_q;
  logic [VEC_W-1:0] off_vec_q;
  logic             trap_pend_q;
  logic [1:0]       trap_op_q;
  logic             post_rst_q;

  logic             boundary, evaluate, trap_now;
  logic [1:0]       trap_op_sel;
  logic             trap_latch_ok;
  exc_type_e        win_type;
  logic [VEC_W-1:0] win_vec;

  exc_rst_detect #(.STAGES(SYNC_STAGES)) u_rst_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (reset_pin_i),
    .wdt_i    (wdt_ovf_i),
    .rst_ev_o (rst_ev)
  );

  exc_boundary_qual #(.ICM_W(2), .TRACE_MODE(2'd2)) u_qual (
    .insn_done_i (insn_done_i),
    .class_i     (class_i),
    .trace_en_i  (trace_en_i),
    .icm_i       (icm_i),
    .irq_req_i   (irq_req_i),
    .post_rst_i  (post_rst_q),
    .trace_ok_o  (trace_ok),
    .irq_ok_o    (irq_ok)
  );

  always_comb begin
    boundary      = insn_done_i | seq_done_i;
    evaluate      = boundary && !off_vld_q && !rst_ev;
    trap_now      = trap_pend_q | trap_i;
    trap_op_sel   = trap_pend_q ? trap_op_q : trap_op_i;
    trap_latch_ok = trap_i && !trap_pend_q &&
                    !(off_vld_q && off_type_q == EXC_RESET);
    arb_req          = '0;
    arb_req[A_TRACE] = trace_ok;
    arb_req[A_IRQ]   = irq_ok;
    arb_req[A_TRAP]  = trap_now;
  end

  exc_arbiter #(.N(ARB_N)) u_arb (
    .req_i (arb_req),
    .gnt_o (arb_gnt)
  );

  always_comb begin
    win_type = EXC_NONE;
    win_vec  = '0;
    if (arb_gnt[A_TRACE]) begin
      win_type = EXC_TRACE;
      win_vec  = VEC_W'(TRACE_VEC);
    end else if (arb_gnt[A_IRQ]) begin
      win_type = EXC_IRQ;
      win_vec  = irq_vec_i;
    end else if (arb_gnt[A_TRAP]) begin
      win_type = EXC_TRAP;
      win_vec  = VEC_W'(TRAP_BASE) + VEC_W'(trap_op_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_vld_q   <= 1'b0;
      off_type_q  <= EXC_NONE;
      off_vec_q   <= '0;
      trap_pend_q <= 1'b0;
      trap_op_q   <= '0;
      post_rst_q  <= 1'b0;
    end else if (rst_ev) begin
      off_vld_q   <= 1'b1;
      off_type_q  <= EXC_RESET;
      off_vec_q   <= '0;
      trap_pend_q <= 1'b0;
    end else begin
      if (off_vld_q && ack_i) begin
        off_vld_q  <= 1'b0;
        off_type_q <= EXC_NONE;
        off_vec_q  <= '0;
        if (off_type_q == EXC_RESET) post_rst_q <= 1'b1;
      end
      if (evaluate) begin
        if (insn_done_i) post_rst_q <= 1'b0;
        if (win_type != EXC_NONE) begin
          off_vld_q  <= 1'b1;
          off_type_q <= win_type;
          off_vec_q  <= win_vec;
        end
        if (arb_gnt[A_TRAP]) begin
          trap_pend_q <= 1'b0;
        end else if (trap_i && !trap_pend_q) begin
          trap_pend_q <= 1'b1;
          trap_op_q   <= trap_op_i;
        end
      end else if (trap_latch_ok) begin
        trap_pend_q <= 1'b1;
        trap_op_q   <= trap_op_i;
      end
    end
  end

  always_comb begin
    take_o     = '0;
    exc_type_o = off_vld_q ? off_type_q : EXC_NONE;
    vec_idx_o  = off_vld_q ? off_vec_q : '0;
    if (off_vld_q) begin
      case (off_type_q)
        EXC_RESET: take_o[SRC_RST]   = 1'b1;
        EXC_TRACE: take_o[SRC_TRACE] = 1'b1;
        EXC_IRQ:   take_o[SRC_IRQ]   = 1'b1;
        EXC_TRAP:  take_o[SRC_TRAP]  = 1'b1;
        default:   take_o            = '0;
      endcase
    end
  end

  // R2
  take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o));

  // R2
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((take_o != '0) && !ack_i && !rst_ev) |=> ($stable(take_o) && $stable(vec_idx_o)));

  // R2
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((take_o != '0) && ack_i && !rst_ev) |=> (take_o == '0));

  // R1
  wdt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf_i |=> take_o[SRC_RST]);

  // R5
  trace_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done_i && class_i == CLS_EXC_RET && take_o == '0 && !rst_ev)
      |=> !take_o[SRC_TRACE]);

  // R5
  trace_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o == '0 && !(trace_en_i && icm_i == 2'd2)) |=> !take_o[SRC_TRACE]);

  // R6
  irq_ccr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done_i && is_ccr_class(class_i) && take_o == '0) |=> !take_o[SRC_IRQ]);

  // R3
  no_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o == '0 && !insn_done_i && !seq_done_i && !rst_ev) |=> (take_o == '0));

endmodule

// File: tb/exc_prio_ctrl_bench.sv
module exc_prio_ctrl_bench;

  localparam int VW = 8;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_pin_i = 1'b0, wdt_ovf_i = 1'b0, trace_en_i = 1'b0;
  logic [1:0] icm_i = 2'd0;
  logic irq_req_i = 1'b0;
  logic [VW-1:0] irq_vec_i = '0;
  logic trap_i = 1'b0;
  logic [1:0] trap_op_i = 2'd0;
  logic insn_done_i = 1'b0, seq_done_i = 1'b0, ack_i = 1'b0;
  logic [2:0] class_i = 3'd0;
  logic [3:0] take_o;
  logic [2:0] exc_type_o;
  logic [VW-1:0] vec_idx_o;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  exc_prio_ctrl #(.VEC_W(VW), .SYNC_STAGES(SS)) u_exc_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_pin_i(reset_pin_i), .wdt_ovf_i(wdt_ovf_i),
    .trace_en_i(trace_en_i), .icm_i(icm_i), .irq_req_i(irq_req_i),
    .irq_vec_i(irq_vec_i), .trap_i(trap_i), .trap_op_i(trap_op_i),
    .insn_done_i(insn_done_i), .class_i(class_i), .seq_done_i(seq_done_i),
    .ack_i(ack_i), .take_o(take_o), .exc_type_o(exc_type_o), .vec_idx_o(vec_idx_o)
  );

  // Behavioural reference model. Source codes: 1 reset, 2 trace, 3 irq, 4 trap.
  int m_src = 0;
  int m_vec = 0;
  bit m_pend = 0;
  int m_op = 0;
  bit m_post = 0;
  bit pin_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_vec = 0; m_pend = 0; m_op = 0; m_post = 0;
      pin_hist = {};
      for (int i = 0; i <= SS; i++) pin_hist.push_back(1'b0);
    end else begin
      bit rise, rev, bnd, busy, tr, iq, tp;
      int old_src, top;
      rise = pin_hist[SS-1] && !pin_hist[SS];
      pin_hist.push_front(reset_pin_i);
      void'(pin_hist.pop_back());
      rev = rise || wdt_ovf_i;
      bnd = insn_done_i || seq_done_i;
      old_src = m_src;
      busy = (old_src != 0);
      if (rev) begin
        m_src = 1; m_vec = 0; m_pend = 0;
      end else begin
        if (busy && ack_i) begin
          if (old_src == 1) m_post = 1;
          m_src = 0; m_vec = 0;
        end
        if (!busy && bnd) begin
          tr = trace_en_i && icm_i == 2 && !(insn_done_i && class_i == 1);
          if (insn_done_i) iq = irq_req_i && !(class_i >= 2 && class_i <= 5);
          else             iq = irq_req_i && !m_post;
          tp = m_pend || trap_i;
          top = m_pend ? m_op : int'(trap_op_i);
          if (insn_done_i) m_post = 0;
          if (tr) begin m_src = 2; m_vec = 5; end
          else if (iq) begin m_src = 3; m_vec = int'(irq_vec_i); end
          else if (tp) begin m_src = 4; m_vec = 8 + top; m_pend = 0; end
          if ((tr || iq) && trap_i && !m_pend) begin m_pend = 1; m_op = int'(trap_op_i); end
        end else if (trap_i && !m_pend && !(busy && old_src == 1)) begin
          m_pend = 1; m_op = int'(trap_op_i);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Advance one cycle, compare against the model, release strobes.
  task automatic tick();
    int et, ee, ev;
    @(negedge clk);
    et = (m_src == 0) ? 0 : (1 << (m_src - 1));
    ee = m_src;
    ev = (m_src == 0) ? 0 : m_vec;
    check(int'(take_o) == et, "R2", "model take_o", int'(take_o), et);
    check(int'(exc_type_o) == ee, "R2", "model exc_type_o", int'(exc_type_o), ee);
    check(int'(vec_idx_o) == ev, "R10", "model vec_idx_o", int'(vec_idx_o), ev);
    wdt_ovf_i = 0; trap_i = 0; insn_done_i = 0; seq_done_i = 0; ack_i = 0;
  endtask

  task automatic expect_offer(input string tag, input int typ, input int vec);
    check(int'(exc_type_o) == typ, tag, "exc_type_o", int'(exc_type_o), typ);
    check(int'(vec_idx_o) == vec, tag, "vec_idx_o", int'(vec_idx_o), vec);
  endtask

  task automatic insn(input int cls);
    insn_done_i = 1; class_i = 3'(cls); tick();
  endtask

  task automatic ack();
    ack_i = 1; tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R11 reset state
    expect_offer("R11", 0, 0);
    check(take_o == 4'b0000, "R11", "take_o after reset", int'(take_o), 0);
    // R3 ack with no offer ignored, boundary with nothing pending gives nothing
    ack(); insn(0); expect_offer("R3", 0, 0);

    // R1 watchdog reset, held until ack (R2)
    wdt_ovf_i = 1; tick();
    expect_offer("R1", 1, 0);
    check(take_o == 4'b0001, "R2", "reset bit", int'(take_o), 1);
    repeat (3) tick();
    expect_offer("R2", 1, 0);
    ack(); expect_offer("R2", 0, 0);

    // R7 interrupt blocked at sequence end after reset, allowed at insn end
    irq_req_i = 1; irq_vec_i = 8'd77;
    seq_done_i = 1; tick(); expect_offer("R7", 0, 0);
    insn(0); expect_offer("R7", 3, 77);
    ack();
    // R6 condition-register classes block the interrupt
    insn(2); expect_offer("R6", 0, 0);
    insn(5); expect_offer("R6", 0, 0);
    insn(4); expect_offer("R6", 0, 0);
    seq_done_i = 1; tick(); expect_offer("R10", 3, 77);
    ack();
    irq_req_i = 0;

    // R5 trace rules
    trace_en_i = 1; icm_i = 2'd0; insn(0); expect_offer("R5", 0, 0);
    icm_i = 2'd2; insn(1); expect_offer("R5", 0, 0);
    insn(0); expect_offer("R5", 2, 5);
    // R3 boundary during outstanding offer, and at ack cycle, ignored
    insn(0); insn_done_i = 1; ack_i = 1; tick();
    expect_offer("R3", 0, 0);

    // R4 trace > irq > trap, R8 late trap
    irq_req_i = 1; irq_vec_i = 8'd40;
    trap_i = 1; trap_op_i = 2'd3; insn(0);
    expect_offer("R4", 2, 5);
    ack(); trace_en_i = 0;
    trap_i = 1; trap_op_i = 2'd0; tick();   // second strobe ignored while pending
    insn(0); expect_offer("R4", 3, 40);
    ack(); irq_req_i = 0;
    insn(0); expect_offer("R8", 4, 11);
    ack(); insn(0); expect_offer("R8", 0, 0);

    // R3 trap strobe with no boundary gives no offer, then taken
    trap_i = 1; trap_op_i = 2'd1; tick();
    expect_offer("R3", 0, 0);
    seq_done_i = 1; tick(); expect_offer("R10", 4, 9);
    ack();

    // R9 pin rise clears pending trap; R1 latency SS+1 edges
    trap_i = 1; trap_op_i = 2'd2; tick();
    reset_pin_i = 1; tick();
    expect_offer("R1", 0, 0);
    repeat (SS - 1) tick();
    expect_offer("R1", 0, 0);
    tick(); expect_offer("R1", 1, 0);
    trap_i = 1; tick();                  // dropped while reset offered
    ack(); insn(0); expect_offer("R9", 0, 0);
    insn(0); expect_offer("R9", 0, 0);
    reset_pin_i = 0; repeat (3) tick();

    // R1 reset replaces an outstanding interrupt offer
    irq_req_i = 1; irq_vec_i = 8'd99; insn(0);
    expect_offer("R1", 3, 99);
    wdt_ovf_i = 1; tick(); expect_offer("R1", 1, 0);
    ack(); irq_req_i = 0;
    insn(0); repeat (2) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule